// File: doc/BRIEF.md
# Page-Mapped Flash Translation Controller with Garbage Collection

This block sits between a host that reads and writes logical pages and a small flash array organised as erase blocks of several pages each. The flash can only program a page that is in the erased state and can only erase a whole block at a time. The controller therefore never rewrites data in place. Every host write lands on a fresh erased page. A logical-to-physical table points at the newest copy, and a one-bit-per-page validity map in on-chip registers marks the older copy as dead.

When the active block is full and only the reserve block is still erased, the controller first stalls the host write and reclaims space. It picks the used block holding the most dead pages, copies that block's live pages into the reserve block, updates their mappings and erases the victim. The erased victim then becomes the new reserve. Two counters, one for physical programs and one for host writes, let the user measure write amplification.

The flash side is a single-outstanding command port: a one-cycle request with command, address and write data, answered by a one-cycle done pulse that carries read data. The page count per block must be a power of two. The number of logical pages must not exceed (blocks - 2) x pages per block, which guarantees that every collection frees at least one page.

Top module: `ftl_core`

## Requirements
- R1: After reset, hostReady is 1, hostDone is 0, flashReq is 0 and both counters read 0.
- R2: A read of a logical page never written since reset completes with hostRdata all ones and hostUnmapped = 1, issues no flash command, and hostDone comes on the second falling edge after the request edge.
- R3: Every page program targets a physical page that is erased, so a new version never lands on the page holding the previous one.
- R4: A read of a written logical page issues one flash read and returns the data of the latest write to that page, with hostUnmapped = 0, even after that page has been relocated.
- R5: Collection starts only when a host write finds the active block full and the number of erased blocks equals RESERVE_BLOCKS (1). With 4 blocks of 4 pages, no erase occurs during the first 12 writes, and one occurs during the 13th.
- R6: The victim is the used block with the most invalid pages; on a tie the lowest block index wins.
- R7: Every still-live page of the victim is read and programmed into the reserve block before the erase, only live pages are copied, and at the erase the victim holds no live page.
- R8: An erase command carries the address of page 0 of the victim block (block index in the upper bits, page offset 0 in the lower log2(pages per block) bits).
- R9: progCount equals the number of program commands issued, and writeCount equals the number of completed host writes.
- R10: hostReady is low from acceptance until hostDone. hostDone lasts one cycle. A write needing no collection is done 5 falling edges after the request edge when the flash answers two cycles after its request. A write that triggers collection takes longer.
- R11: flashCmd encodes 1 = page read, 2 = page program, 3 = block erase, and flashReq is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Request strobe, accepted when hostReady is high |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostLpn | input | log2(NUM_LPAGES) | Logical page number |
| hostWdata | input | DATA_W | Write data |
| hostReady | output | 1 | Controller idle and able to accept |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | DATA_W | Read data, valid with hostDone |
| hostUnmapped | output | 1 | Read hit a never-written page, valid with hostDone |
| flashReq | output | 1 | One-cycle flash command strobe |
| flashCmd | output | 2 | 1 read, 2 program, 3 erase |
| flashAddr | output | log2(NUM_BLOCKS)+log2(PAGES_PER_BLOCK) | Physical page address, {block, offset} |
| flashWdata | output | DATA_W | Program data |
| flashDone | input | 1 | Flash completion pulse |
| flashRdata | input | DATA_W | Read data, valid with flashDone |
| progCount | output | CNT_W | Physical programs performed |
| writeCount | output | CNT_W | Host writes completed |

## Verification
An unmapped read is due exactly two falling edges after its request edge. A write without collection, and a flash-backed read, are due five edges after the request because the flash model answers two cycles after each command. Those fixed latencies are compared exactly. Writes that trigger collection are only required to be slower. Results are taken on the falling edge at which hostDone is seen, and counters are compared only between operations. The flash model judges each command on the falling edge where flashReq is seen: erased-only programs, relocation of live pages only, victim choice and erase alignment.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

  typedef enum logic [1:0] {
    FCMD_NONE  = 2'd0,
    FCMD_READ  = 2'd1,
    FCMD_PROG  = 2'd2,
    FCMD_ERASE = 2'd3
  } flash_cmd_e;

  typedef enum logic [1:0] {
    ASEL_HOST   = 2'd0,
    ASEL_VICTIM = 2'd1,
    ASEL_ACTIVE = 2'd2,
    ASEL_ERASE  = 2'd3
  } addr_sel_e;

  typedef struct packed {
    logic      latchReq;
    logic      openBlock;
    logic      commitHost;
    logic      commitReloc;
    logic      capture;
    logic      setUnmapped;
    logic      pickVictim;
    logic      stepReloc;
    logic      eraseVictim;
    addr_sel_e addrSel;
    logic      dataFromBuf;
  } ftl_strobe_t;

endpackage

// File: rtl/ftl_datapath.sv
module ftl_datapath
  import ftl_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_LPAGES      = 8,
  parameter int DATA_W          = 16,
  parameter int CNT_W           = 16,
  parameter int RESERVE_BLOCKS  = 1
) (
  input  logic                                                  clk,
  input  logic                                                  rstN,
  input  ftl_strobe_t                                           stb,
  input  logic [$clog2(NUM_LPAGES)-1:0]                         hostLpn,
  input  logic [DATA_W-1:0]                                     hostWdata,
  input  logic [DATA_W-1:0]                                     flashRdata,
  output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] flashAddr,
  output logic [DATA_W-1:0]                                     flashWdata,
  output logic [DATA_W-1:0]                                     hostRdata,
  output logic                                                  hostUnmapped,
  output logic [CNT_W-1:0]                                      progCount,
  output logic [CNT_W-1:0]                                      writeCount,
  output logic                                                  curMapped,
  output logic                                                  needBlock,
  output logic                                                  canOpenHost,
  output logic                                                  relocValid,
  output logic                                                  relocLast
);

  localparam int OFF_W  = $clog2(PAGES_PER_BLOCK);
  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int PPN_W  = BLK_W + OFF_W;
  localparam int LPN_W  = $clog2(NUM_LPAGES);
  localparam int PPAGES = NUM_BLOCKS * PAGES_PER_BLOCK;

  // request latch and data buffer
  logic [LPN_W-1:0]  lpnReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] bufData;
  logic              unmappedReg;

  // translation state
  logic [NUM_LPAGES-1:0] mapValid;
  logic [PPN_W-1:0]      mapPpn [NUM_LPAGES];
  logic [LPN_W-1:0]      revLpn [PPAGES];
  logic [PPAGES-1:0]     validBits;
  logic [PPAGES-1:0]     progBits;

  // block allocation state
  logic [NUM_BLOCKS-1:0] blkFree;
  logic [BLK_W-1:0]      activeBlk;
  logic [BLK_W-1:0]      victimBlk;
  logic                  hasActive;
  logic [OFF_W:0]        wrPtr;
  logic [OFF_W-1:0]      relocOff;

  logic [BLK_W:0]     freeCount;
  logic [BLK_W-1:0]   firstFree;
  logic [BLK_W-1:0]   bestBlk;
  logic [PPN_W-1:0]   newPpn;
  logic [PPN_W-1:0]   relocPpn;
  logic [PPN_W-1:0]   curPpn;
  logic [LPN_W-1:0]   commitLpn;
  logic               doCommit;

  assign newPpn    = {activeBlk, wrPtr[OFF_W-1:0]};
  assign relocPpn  = {victimBlk, relocOff};
  assign curPpn    = mapPpn[lpnReg];
  assign commitLpn = stb.commitReloc ? revLpn[relocPpn] : lpnReg;
  assign doCommit  = stb.commitHost | stb.commitReloc;

  // erased-block census and lowest free block
  always_comb begin
    freeCount = '0;
    firstFree = '0;
    for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
      if (blkFree[b]) begin
        freeCount = freeCount + (BLK_W+1)'(1);
        firstFree = BLK_W'(b);
      end
    end
  end

  // victim choice: strictly greater keeps the lowest index on ties
  always_comb begin
    logic [OFF_W:0] bestInv;
    logic [OFF_W:0] invCnt;
    bestBlk = '0;
    bestInv = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      invCnt = '0;
      for (int o = 0; o < PAGES_PER_BLOCK; o++) begin
        if (progBits[b*PAGES_PER_BLOCK + o] && !validBits[b*PAGES_PER_BLOCK + o])
          invCnt = invCnt + (OFF_W+1)'(1);
      end
      if (!blkFree[b] && invCnt > bestInv) begin
        bestInv = invCnt;
        bestBlk = BLK_W'(b);
      end
    end
  end

  // flash address and data selection
  always_comb begin
    unique case (stb.addrSel)
      ASEL_HOST:   flashAddr = curPpn;
      ASEL_VICTIM: flashAddr = relocPpn;
      ASEL_ACTIVE: flashAddr = newPpn;
      default:     flashAddr = {victimBlk, {OFF_W{1'b0}}};
    endcase
  end
  assign flashWdata = stb.dataFromBuf ? bufData : wdataReg;

  // status toward the control
  assign curMapped   = mapValid[lpnReg];
  assign needBlock   = !hasActive || (wrPtr == (OFF_W+1)'(PAGES_PER_BLOCK));
  assign canOpenHost = freeCount > (BLK_W+1)'(RESERVE_BLOCKS);
  assign relocValid  = validBits[relocPpn];
  assign relocLast   = relocOff == OFF_W'(PAGES_PER_BLOCK - 1);

  assign hostRdata    = bufData;
  assign hostUnmapped = unmappedReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lpnReg      <= '0;
      wdataReg    <= '0;
      bufData     <= '0;
      unmappedReg <= 1'b0;
      mapValid    <= '0;
      validBits   <= '0;
      progBits    <= '0;
      blkFree     <= '1;
      activeBlk   <= '0;
      victimBlk   <= '0;
      hasActive   <= 1'b0;
      wrPtr       <= '0;
      relocOff    <= '0;
      progCount   <= '0;
      writeCount  <= '0;
      for (int l = 0; l < NUM_LPAGES; l++) mapPpn[l] <= '0;
      for (int p = 0; p < PPAGES; p++) revLpn[p] <= '0;
    end else begin
      if (stb.latchReq) begin
        lpnReg   <= hostLpn;
        wdataReg <= hostWdata;
      end
      if (stb.openBlock) begin
        blkFree[firstFree] <= 1'b0;
        activeBlk          <= firstFree;
        wrPtr              <= '0;
        hasActive          <= 1'b1;
      end
      if (doCommit) begin
        if (mapValid[commitLpn]) validBits[mapPpn[commitLpn]] <= 1'b0;
        validBits[newPpn]   <= 1'b1;
        progBits[newPpn]    <= 1'b1;
        mapValid[commitLpn] <= 1'b1;
        mapPpn[commitLpn]   <= newPpn;
        revLpn[newPpn]      <= commitLpn;
        wrPtr               <= wrPtr + (OFF_W+1)'(1);
        progCount           <= progCount + CNT_W'(1);
        if (stb.commitHost) writeCount <= writeCount + CNT_W'(1);
      end
      if (stb.capture) begin
        bufData     <= flashRdata;
        unmappedReg <= 1'b0;
      end
      if (stb.setUnmapped) begin
        bufData     <= '1;
        unmappedReg <= 1'b1;
      end
      if (stb.pickVictim) begin
        victimBlk <= bestBlk;
        relocOff  <= '0;
      end
      if (stb.stepReloc) relocOff <= relocOff + OFF_W'(1);
      if (stb.eraseVictim) begin
        blkFree[victimBlk] <= 1'b1;
        for (int o = 0; o < PAGES_PER_BLOCK; o++) begin
          progBits[{victimBlk, OFF_W'(o)}]  <= 1'b0;
          validBits[{victimBlk, OFF_W'(o)}] <= 1'b0;
        end
      end
    end
  end

  // R3: a program commit lands on a page not written since its erase
  a_r3_prog_into_erased: assert property (@(posedge clk) disable iff (!rstN)
    doCommit |-> (hasActive && !progBits[newPpn] &&
                  wrPtr < (OFF_W+1)'(PAGES_PER_BLOCK)));

  // R7: the victim holds no live page when it is erased
  a_r7_victim_drained: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseVictim |-> (validBits[victimBlk*PAGES_PER_BLOCK +: PAGES_PER_BLOCK] == '0));

  // R8: only a used block that is not the write target gets erased
  a_r8_erase_used_block: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseVictim |-> (!blkFree[victimBlk] && victimBlk != activeBlk));

  // R5: a block is only opened while an erased one exists
  a_r5_open_has_free: assert property (@(posedge clk) disable iff (!rstN)
    stb.openBlock |-> (freeCount != '0));

  // R9: physical programs never trail host writes
  a_r9_prog_ge_write: assert property (@(posedge clk) disable iff (!rstN)
    progCount >= writeCount);

  // R2: an unmapped result always carries all ones
  a_r2_unmapped_ones: assert property (@(posedge clk) disable iff (!rstN)
    unmappedReg |-> (&bufData));

endmodule

// File: rtl/ftl_control.sv
module ftl_control
  import ftl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        hostWrite,
  input  logic        curMapped,
  input  logic        needBlock,
  input  logic        canOpenHost,
  input  logic        relocValid,
  input  logic        relocLast,
  input  logic        flashDone,
  output ftl_strobe_t stb,
  output logic        hostReady,
  output logic        hostDone,
  output logic        flashReq,
  output logic [1:0]  flashCmd
);

  typedef enum logic [3:0] {
    S_IDLE, S_RCHK, S_RISSUE, S_RWAIT,
    S_WALLOC, S_WPROG, S_WWAIT,
    S_GPICK, S_GSCAN, S_GREAD, S_GRWAIT, S_GPROG, S_GPWAIT,
    S_GERASE, S_GEWAIT, S_DONE
  } state_e;

  state_e     state, stateNext;
  flash_cmd_e cmdNow;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    cmdNow    = FCMD_NONE;
    unique case (state)
      S_IDLE: if (hostReq) begin
        stb.latchReq = 1'b1;
        stateNext    = hostWrite ? S_WALLOC : S_RCHK;
      end
      S_RCHK: if (curMapped) stateNext = S_RISSUE;
              else begin
                stb.setUnmapped = 1'b1;
                stateNext       = S_DONE;
              end
      S_RISSUE: begin
        cmdNow      = FCMD_READ;
        stb.addrSel = ASEL_HOST;
        stateNext   = S_RWAIT;
      end
      S_RWAIT: if (flashDone) begin
        stb.capture = 1'b1;
        stateNext   = S_DONE;
      end
      S_WALLOC: begin
        if (!needBlock) stateNext = S_WPROG;
        else if (canOpenHost) begin
          stb.openBlock = 1'b1;
          stateNext     = S_WPROG;
        end else stateNext = S_GPICK;
      end
      S_WPROG: begin
        cmdNow      = FCMD_PROG;
        stb.addrSel = ASEL_ACTIVE;
        stateNext   = S_WWAIT;
      end
      S_WWAIT: if (flashDone) begin
        stb.commitHost = 1'b1;
        stateNext      = S_DONE;
      end
      S_GPICK: begin
        stb.pickVictim = 1'b1;
        stb.openBlock  = 1'b1;
        stateNext      = S_GSCAN;
      end
      S_GSCAN: begin
        if (relocValid) stateNext = S_GREAD;
        else if (relocLast) stateNext = S_GERASE;
        else stb.stepReloc = 1'b1;
      end
      S_GREAD: begin
        cmdNow      = FCMD_READ;
        stb.addrSel = ASEL_VICTIM;
        stateNext   = S_GRWAIT;
      end
      S_GRWAIT: if (flashDone) begin
        stb.capture = 1'b1;
        stateNext   = S_GPROG;
      end
      S_GPROG: begin
        cmdNow          = FCMD_PROG;
        stb.addrSel     = ASEL_ACTIVE;
        stb.dataFromBuf = 1'b1;
        stateNext       = S_GPWAIT;
      end
      S_GPWAIT: if (flashDone) begin
        stb.commitReloc = 1'b1;
        if (relocLast) stateNext = S_GERASE;
        else begin
          stb.stepReloc = 1'b1;
          stateNext     = S_GSCAN;
        end
      end
      S_GERASE: begin
        cmdNow      = FCMD_ERASE;
        stb.addrSel = ASEL_ERASE;
        stateNext   = S_GEWAIT;
      end
      S_GEWAIT: if (flashDone) begin
        stb.eraseVictim = 1'b1;
        stateNext       = S_WALLOC;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign hostReady = state == S_IDLE;
  assign hostDone  = state == S_DONE;
  assign flashReq  = cmdNow != FCMD_NONE;
  assign flashCmd  = cmdNow;

  // R11: each flash command is a single-cycle strobe
  a_r11_req_single: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |=> !flashReq);

  // R10: completion is a single cycle and returns to accepting
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> (!hostDone && hostReady));

  // R10: no flash activity while the host side is idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> !flashReq);

endmodule

// File: rtl/ftl_core.sv
module ftl_core
  import ftl_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_LPAGES      = 8,
  parameter int DATA_W          = 16,
  parameter int CNT_W           = 16,
  parameter int RESERVE_BLOCKS  = 1
) (
  input  logic                                                  clk,
  input  logic                                                  rstN,
  input  logic                                                  hostReq,
  input  logic                                                  hostWrite,
  input  logic [$clog2(NUM_LPAGES)-1:0]                         hostLpn,
  input  logic [DATA_W-1:0]                                     hostWdata,
  output logic                                                  hostReady,
  output logic                                                  hostDone,
  output logic [DATA_W-1:0]                                     hostRdata,
  output logic                                                  hostUnmapped,
  output logic                                                  flashReq,
  output logic [1:0]                                            flashCmd,
  output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] flashAddr,
  output logic [DATA_W-1:0]                                     flashWdata,
  input  logic                                                  flashDone,
  input  logic [DATA_W-1:0]                                     flashRdata,
  output logic [CNT_W-1:0]                                      progCount,
  output logic [CNT_W-1:0]                                      writeCount
);

  ftl_strobe_t stb;
  logic curMapped, needBlock, canOpenHost, relocValid, relocLast;

  ftl_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .hostReq     (hostReq),
    .hostWrite   (hostWrite),
    .curMapped   (curMapped),
    .needBlock   (needBlock),
    .canOpenHost (canOpenHost),
    .relocValid  (relocValid),
    .relocLast   (relocLast),
    .flashDone   (flashDone),
    .stb         (stb),
    .hostReady   (hostReady),
    .hostDone    (hostDone),
    .flashReq    (flashReq),
    .flashCmd    (flashCmd)
  );

  ftl_datapath #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .NUM_LPAGES      (NUM_LPAGES),
    .DATA_W          (DATA_W),
    .CNT_W           (CNT_W),
    .RESERVE_BLOCKS  (RESERVE_BLOCKS)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .hostLpn      (hostLpn),
    .hostWdata    (hostWdata),
    .flashRdata   (flashRdata),
    .flashAddr    (flashAddr),
    .flashWdata   (flashWdata),
    .hostRdata    (hostRdata),
    .hostUnmapped (hostUnmapped),
    .progCount    (progCount),
    .writeCount   (writeCount),
    .curMapped    (curMapped),
    .needBlock    (needBlock),
    .canOpenHost  (canOpenHost),
    .relocValid   (relocValid),
    .relocLast    (relocLast)
  );

endmodule

// File: tb/ftl_core_bench.sv
module ftl_core_bench;

  localparam int NB = 4;
  localparam int PB = 4;
  localparam int NL = 8;
  localparam int DW = 16;
  localparam int NP = NB * PB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0;
  logic          hostWrite = 1'b0;
  logic [2:0]    hostLpn = '0;
  logic [DW-1:0] hostWdata = '0;
  logic          hostReady, hostDone, hostUnmapped, flashReq;
  logic [DW-1:0] hostRdata, flashWdata;
  logic [1:0]    flashCmd;
  logic [3:0]    flashAddr;
  logic          flashDone = 1'b0;
  logic [DW-1:0] flashRdata = '0;
  logic [15:0]   progCount, writeCount;

  always #4 clk = ~clk;  // 125 MHz

  ftl_core u_ftl_core (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostLpn(hostLpn), .hostWdata(hostWdata), .hostReady(hostReady),
    .hostDone(hostDone), .hostRdata(hostRdata), .hostUnmapped(hostUnmapped),
    .flashReq(flashReq), .flashCmd(flashCmd), .flashAddr(flashAddr),
    .flashWdata(flashWdata), .flashDone(flashDone), .flashRdata(flashRdata),
    .progCount(progCount), .writeCount(writeCount)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural flash with its own observation of validity
  logic [DW-1:0] pageData [NP];
  bit            pageWritten [NP];
  int            curPage [16];
  int            busyCnt = 0;
  int            progSeen = 0, readSeen = 0, eraseSeen = 0;
  int            gcReads = 0, gcReadsTotal = 0, lastErase = -1;
  bit            hostReading = 0;

  function automatic bit isLive(int p);
    return pageWritten[p] && curPage[pageData[p][15:12]] == p;
  endfunction

  initial begin
    for (int p = 0; p < NP; p++) begin pageWritten[p] = 0; pageData[p] = '1; end
    for (int l = 0; l < 16; l++) curPage[l] = -1;
  end

  always @(negedge clk) begin
    flashDone = 1'b0;
    if (busyCnt != 0) begin
      busyCnt--;
      if (busyCnt == 0) flashDone = 1'b1;
    end
    if (rstN && flashReq) begin
      busyCnt = 2;
      check(flashCmd != 2'd0, "R11", "command code", flashCmd, 1);
      if (flashCmd == 2'd2) begin
        check(!pageWritten[flashAddr], "R3", "program on unerased page", flashAddr, -1);
        pageWritten[flashAddr] = 1;
        pageData[flashAddr]    = flashWdata;
        curPage[flashWdata[15:12]] = int'(flashAddr);
        progSeen++;
      end else if (flashCmd == 2'd1) begin
        flashRdata = pageData[flashAddr];
        readSeen++;
        if (!hostReading) begin
          check(isLive(int'(flashAddr)), "R7", "relocated page live", flashAddr, 1);
          gcReads++;
          gcReadsTotal++;
        end
      end else if (flashCmd == 2'd3) begin
        int vb, vInv, unwritten;
        check(flashAddr[1:0] == 2'd0, "R8", "erase offset", flashAddr[1:0], 0);
        vb = int'(flashAddr[3:2]);
        for (int o = 0; o < PB; o++)
          check(!isLive(vb*PB + o), "R7", "live page at erase", vb*PB + o, -1);
        vInv = PB - gcReads;
        unwritten = 0;
        for (int c = 0; c < NB; c++) begin
          int wc, inv;
          wc = 0; inv = 0;
          for (int o = 0; o < PB; o++) begin
            if (pageWritten[c*PB + o]) begin
              wc++;
              if (!isLive(c*PB + o)) inv++;
            end
          end
          if (wc == 0) unwritten++;
          else if (c != vb)
            check(inv < vInv || (inv == vInv && c > vb), "R6", "victim rank", vb, c);
        end
        check(unwritten == (gcReads == 0 ? 1 : 0), "R5", "erased blocks at collection",
              unwritten, gcReads == 0 ? 1 : 0);
        for (int o = 0; o < PB; o++) begin
          pageWritten[vb*PB + o] = 0;
          pageData[vb*PB + o] = '1;
        end
        gcReads = 0;
        lastErase = int'(flashAddr);
        eraseSeen++;
      end
    end
  end

  // host side
  logic [DW-1:0] shadow [NL];
  bit            shadowSet [NL];
  int            hostWrites = 0;
  int            seq = 0;
  int            lastLat = 0;

  task automatic doWrite(input int lpn);
    logic [DW-1:0] d;
    seq++;
    d = {4'(lpn), 12'(seq)};
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostReq = 1; hostWrite = 1; hostLpn = 3'(lpn); hostWdata = d;
    @(negedge clk);
    hostReq = 0;
    lastLat = 1;
    while (!hostDone) begin @(negedge clk); lastLat++; end
    hostWrites++;
    shadow[lpn] = d;
    shadowSet[lpn] = 1;
  endtask

  task automatic doRead(input int lpn, output logic [DW-1:0] d, output bit unm);
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostReading = 1;
    hostReq = 1; hostWrite = 0; hostLpn = 3'(lpn);
    @(negedge clk);
    hostReq = 0;
    lastLat = 1;
    while (!hostDone) begin @(negedge clk); lastLat++; end
    d = hostRdata;
    unm = hostUnmapped;
    hostReading = 0;
  endtask

  task automatic readAll(input string tag);
    logic [DW-1:0] d;
    bit unm;
    for (int l = 0; l < NL; l++) begin
      if (!shadowSet[l]) continue;
      doRead(l, d, unm);
      check(d == shadow[l], "R4", {tag, " data"}, d, shadow[l]);
      check(!unm, "R4", {tag, " mapped flag"}, unm, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    bit unm;
    int r0, lat12;
    for (int l = 0; l < NL; l++) shadowSet[l] = 0;
    repeat (4) @(negedge clk);
    check(hostReady == 1, "R1", "ready in reset", hostReady, 1);
    rstN = 1;
    repeat (3) begin
      @(negedge clk);
      check(!flashReq && !hostDone, "R1", "quiet after reset", flashReq, 0);
    end
    check(hostReady == 1, "R1", "ready", hostReady, 1);
    check(progCount == 0 && writeCount == 0, "R1", "counters", progCount, 0);

    // unmapped sweep
    r0 = readSeen;
    for (int l = 0; l < NL; l++) begin
      doRead(l, d, unm);
      check(unm == 1, "R2", "unmapped flag", unm, 1);
      check(d == 16'hFFFF, "R2", "all ones", d, 16'hFFFF);
      check(lastLat == 2, "R2", "latency", lastLat, 2);
    end
    check(readSeen == r0 && progSeen == 0, "R2", "no flash op", readSeen - r0, 0);

    // fill sequence: 12 writes without collection
    for (int i = 0; i < 12; i++) begin
      doWrite(i % NL);
      check(lastLat == 5, "R10", "plain write latency", lastLat, 5);
      lat12 = lastLat;
    end
    check(eraseSeen == 0, "R5", "no erase in first 12", eraseSeen, 0);
    check(progCount == 12 && writeCount == 12, "R9", "counts after 12", progCount, 12);
    doRead(5, d, unm);
    check(lastLat == 5, "R4", "read latency", lastLat, 5);
    check(d == shadow[5], "R4", "read lpn5", d, shadow[5]);

    // 13th write triggers collection of block 0 (all four pages stale)
    doWrite(4);
    check(eraseSeen == 1, "R5", "erase on write 13", eraseSeen, 1);
    check(lastErase == 0, "R6", "victim block 0 address", lastErase, 0);
    check(gcReadsTotal == 0, "R7", "nothing to relocate", gcReadsTotal, 0);
    check(lastLat > lat12, "R10", "stall during collection", lastLat, lat12 + 1);
    check(progCount == 13 && writeCount == 13, "R9", "counts after 13",
          progCount, 13);
    readAll("after first collection");

    // hot/cold sweep forcing relocation of cold pages
    for (int i = 0; i < 400; i++) begin
      int lpn;
      lpn = (i % 8 == 7) ? 2 + ((i / 8) % 6) : (i % 2);
      doWrite(lpn);
      if (i % 50 == 49) readAll("sweep");
    end
    readAll("final");
    check(int'(progCount) == progSeen, "R9", "programs counted", progCount, progSeen);
    check(int'(writeCount) == hostWrites, "R9", "writes counted", writeCount, hostWrites);
    check(gcReadsTotal > 0, "R7", "relocations occurred", gcReadsTotal, 1);
    check(int'(progCount) == hostWrites + gcReadsTotal, "R9", "amplification",
          progCount, hostWrites + gcReadsTotal);
    check(eraseSeen > 1, "R5", "repeated collection", eraseSeen, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule